// File: doc/BRIEF.md
# Multiplexed LCD Common Timing Generator

This block turns an oscillator clock into the frame timing of a multiplexed LCD. It steps through the common phases for static, 1/2, 1/3 or 1/4 duty operation. One frame always lasts 24 oscillator cycles, and those cycles are shared evenly among the active commons. Each phase slot is split into a positive half and a negative half, so every common electrode sees no net DC.

For each cycle the block reports four things:
- the active phase index and its polarity;
- a two-bit drive-level code for every common output;
- a one-hot select that picks which 160-bit quarter of a 640-bit segment latch feeds the segment drivers;
- a frame-start pulse on the sync output.

Several devices can share one sync line. One device is set as master and drives the line. The others are slaves: they watch the line and restart their frame so that they stay in step with the master cycle for cycle.

All outputs are decoded directly from the internal counters. Each output therefore shows the state reached at the most recent rising clock edge. Inputs take effect at the edge that samples them.

Top module: `lcd_com_timing`

## Requirements
- R1: While `rst_n` is low, the block sits at frame tick 0 in static mode. This means `phase_idx` = 0, `polarity` = 0, `bank_sel` = 4'b0001, common 0 carries the select code, and `sync_out` equals `is_master`.
- R2: A frame is 24 clock cycles long. `duty_sel` encodes the mode as 0 = static (1 common), 1 = 1/2, 2 = 1/3 and 3 = 1/4 duty. In a mode with N commons, `phase_idx` holds each value 0..N-1 for 24/N cycles in ascending order, then wraps to 0.
- R3: `polarity` is 0 for the first half of every phase slot and 1 for the second half.
- R4: Common i has a 2-bit level code at bits [2i+1:2i] of `com_level`. The upper bit is 1 for select and 0 for non-select; the lower bit equals `polarity`. Codes are 00 non-select positive, 01 non-select negative, 10 select positive, 11 select negative. Only the common whose index equals `phase_idx` gets the select code. Every other common, including those unused in lower-duty modes, gets the non-select code.
- R5: `bank_sel` is one-hot, with bit `phase_idx` set. It names the latch quarter that drives the segments.
- R6: When `is_master` is 1, `sync_out` is high exactly in frame tick 0 (phase 0, first cycle of the slot) and low in every other cycle. `sync_in` has no effect in this mode.
- R7: When `is_master` is 0, `sync_out` stays low. A rising edge on `sync_in`, sampled at a clock edge, places the block at frame tick 1 (phase 0) after that edge, which keeps it aligned with the master that drove tick 0. Holding `sync_in` high causes no further restart.
- R8: After any edge where `duty_sel` differs from its value at the previous edge, the block is at frame tick 0 of the new mode. This restart takes precedence over a simultaneous sync edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_sel | input | 2 | Duty mode: 0 static, 1 half, 2 third, 3 quarter |
| is_master | input | 1 | 1 = drive the sync line, 0 = follow it |
| sync_in | input | 1 | Shared sync line as seen by a slave |
| phase_idx | output | 2 | Active common phase |
| polarity | output | 1 | Drive polarity of the current half slot |
| com_level | output | 8 | Two-bit level code per common |
| bank_sel | output | 4 | One-hot segment latch quarter select |
| sync_out | output | 1 | Frame-start pulse (master only) |

## Verification
Inputs are sampled at a rising edge, and their effects are visible in the cycle right after that edge. A restart caused by a sync edge or a mode change shows up one edge later, not two. The bench drives inputs on the falling edge. For each driven cycle it pushes the expected frame tick into a queue. A monitor pops that tick 2 ns after the next rising edge and derives the expected phase, polarity, level codes, bank select and sync value from the tick using the requirement arithmetic. Every comparison therefore lands in the cycle where the result is due.

// File: rtl/lcd_com_pkg.sv
`timescale 1ns/1ps
package lcd_com_pkg;

   localparam int LVL_W = 2;

   // upper bit: select, lower bit: negative half
   typedef enum logic [LVL_W-1:0] {
      LVL_NSEL_POS = 2'b00,
      LVL_NSEL_NEG = 2'b01,
      LVL_SEL_POS  = 2'b10,
      LVL_SEL_NEG  = 2'b11
   } com_lvl_e;

   function automatic com_lvl_e lvl_of(input logic is_sel, input logic neg);
      return com_lvl_e'({is_sel, neg});
   endfunction

endpackage

// File: rtl/lcd_sync_ctl.sv
`timescale 1ns/1ps
module lcd_sync_ctl #(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] duty_sel,
   input  logic              is_master,
   input  logic              sync_in,
   input  logic              frame_start,
   output logic [MODE_W-1:0] mode_q,
   output logic              restart,
   output logic              align,
   output logic              sync_out
);

   logic sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         sync_q <= 1'b0;
      end else begin
         mode_q <= duty_sel;
         sync_q <= sync_in;
      end
   end

   // a new mode restarts the frame
   assign restart  = (duty_sel != mode_q);
   // slave follows rising edges of the shared line only
   assign align    = !is_master && sync_in && !sync_q;
   assign sync_out = is_master && frame_start;

endmodule

// File: rtl/lcd_phase_seq.sv
`timescale 1ns/1ps
module lcd_phase_seq #(
   parameter int FRAME_TICKS = 24,
   parameter int NUM_COM     = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(NUM_COM)-1:0] mode,
   input  logic                       restart,
   input  logic                       align,
   output logic [$clog2(NUM_COM)-1:0] phase,
   output logic                       polarity,
   output logic                       frame_start
);

   localparam int MODE_W = $clog2(NUM_COM);
   localparam int SUB_W  = $clog2(FRAME_TICKS);

   logic [SUB_W-1:0]  slot_last [NUM_COM];
   logic [SUB_W-1:0]  half_len  [NUM_COM];
   logic [SUB_W-1:0]  sub_q, sub_d;
   logic [MODE_W-1:0] phase_q, phase_d;

   // slot geometry per mode, constant per generate branch
   for (genvar g = 0; g < NUM_COM; g++) begin : g_slot
      assign slot_last[g] = SUB_W'(FRAME_TICKS / (g + 1) - 1);
      assign half_len[g]  = SUB_W'(FRAME_TICKS / (2 * (g + 1)));
   end

   always_comb begin
      sub_d   = sub_q + SUB_W'(1);
      phase_d = phase_q;
      if (restart) begin
         sub_d   = '0;
         phase_d = '0;
      end else if (align) begin
         // the master showed tick 0 in this cycle
         sub_d   = SUB_W'(1);
         phase_d = '0;
      end else if (sub_q == slot_last[mode]) begin
         sub_d   = '0;
         phase_d = (phase_q == mode) ? '0 : phase_q + MODE_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q   <= '0;
         phase_q <= '0;
      end else begin
         sub_q   <= sub_d;
         phase_q <= phase_d;
      end
   end

   assign phase       = phase_q;
   assign polarity    = (sub_q >= half_len[mode]);
   assign frame_start = (phase_q == '0) && (sub_q == '0);

endmodule

// File: rtl/lcd_com_encode.sv
`timescale 1ns/1ps
module lcd_com_encode
   import lcd_com_pkg::*;
#(
   parameter int NUM_COM = 4
) (
   input  logic [$clog2(NUM_COM)-1:0] phase,
   input  logic                       polarity,
   output logic [NUM_COM*LVL_W-1:0]   com_level,
   output logic [NUM_COM-1:0]         bank_sel
);

   localparam int MODE_W = $clog2(NUM_COM);

   for (genvar g = 0; g < NUM_COM; g++) begin : g_com
      logic hit;
      assign hit                         = (phase == MODE_W'(g));
      assign bank_sel[g]                 = hit;
      assign com_level[g*LVL_W +: LVL_W] = lvl_of(hit, polarity);
   end

endmodule

// File: rtl/lcd_com_timing.sv
`timescale 1ns/1ps
module lcd_com_timing
   import lcd_com_pkg::*;
#(
   parameter int FRAME_TICKS = 24,
   parameter int NUM_COM     = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(NUM_COM)-1:0] duty_sel,
   input  logic                       is_master,
   input  logic                       sync_in,
   output logic [$clog2(NUM_COM)-1:0] phase_idx,
   output logic                       polarity,
   output logic [NUM_COM*LVL_W-1:0]   com_level,
   output logic [NUM_COM-1:0]         bank_sel,
   output logic                       sync_out
);

   localparam int MODE_W = $clog2(NUM_COM);

   // elaboration-time parameter checks
   if (NUM_COM < 2 || (1 << MODE_W) != NUM_COM) begin : g_bad_com
      initial $fatal(1, "NUM_COM must be a power of two, at least 2");
   end
   for (genvar g = 0; g < NUM_COM; g++) begin : g_chk_ticks
      if (FRAME_TICKS % (2 * (g + 1)) != 0) begin : g_bad
         initial $fatal(1, "FRAME_TICKS must split into equal half slots");
      end
   end

   logic [MODE_W-1:0] mode_q;
   logic              restart, align, frame_start;

   lcd_sync_ctl #(.MODE_W(MODE_W)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .duty_sel   (duty_sel),
      .is_master  (is_master),
      .sync_in    (sync_in),
      .frame_start(frame_start),
      .mode_q     (mode_q),
      .restart    (restart),
      .align      (align),
      .sync_out   (sync_out)
   );

   lcd_phase_seq #(.FRAME_TICKS(FRAME_TICKS), .NUM_COM(NUM_COM)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode_q),
      .restart    (restart),
      .align      (align),
      .phase      (phase_idx),
      .polarity   (polarity),
      .frame_start(frame_start)
   );

   lcd_com_encode #(.NUM_COM(NUM_COM)) u_enc (
      .phase    (phase_idx),
      .polarity (polarity),
      .com_level(com_level),
      .bank_sel (bank_sel)
   );

endmodule

// File: rtl/lcd_com_timing_chk.sv
`timescale 1ns/1ps
module lcd_com_timing_chk #(
   parameter int NUM_COM = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [$clog2(NUM_COM)-1:0] duty_sel,
   input logic                       is_master,
   input logic                       sync_in,
   input logic [$clog2(NUM_COM)-1:0] phase_idx,
   input logic                       polarity,
   input logic [NUM_COM*2-1:0]       com_level,
   input logic [NUM_COM-1:0]         bank_sel,
   input logic                       sync_out
);

   logic [NUM_COM-1:0] sel_bits;

   for (genvar g = 0; g < NUM_COM; g++) begin : g_lvl
      assign sel_bits[g] = com_level[2*g+1];
      assert_com_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
         com_level[2*g] == polarity);
   end

   assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> phase_idx <= $past(duty_sel));

   assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel_bits) == 1);

   assert_bank_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(bank_sel) == 1) && bank_sel[phase_idx]);

   assert_sync_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_out |=> !sync_out);

   assert_slave_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !is_master |-> !sync_out);

   assert_slave_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_master && $rose(sync_in) && $stable(duty_sel)) |=> (phase_idx == '0 && !polarity));

   assert_mode_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_sel != $past(duty_sel)) |=> (phase_idx == '0 && !polarity && sync_out == is_master));

endmodule

bind lcd_com_timing lcd_com_timing_chk #(.NUM_COM(NUM_COM)) u_chk (.*);

// File: tb/sim_lcd_com_timing.sv
`timescale 1ns/1ps
module sim_lcd_com_timing;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] duty_sel;
   logic       is_master;
   logic       sync_in;
   logic [1:0] phase_idx;
   logic       polarity;
   logic [7:0] com_level;
   logic [3:0] bank_sel;
   logic       sync_out;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 0;

   typedef struct {
      int k;
      int m;
      bit mst;
      int tag;
   } item_t;

   item_t q[$];
   int    cur_k = 0;
   int    cur_m = 0;
   bit    prev_sync = 0;

   always #2.5 clk = ~clk;

   lcd_com_timing u0 (
      .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .is_master(is_master),
      .sync_in(sync_in), .phase_idx(phase_idx), .polarity(polarity),
      .com_level(com_level), .bank_sel(bank_sel), .sync_out(sync_out)
   );

   function automatic string tagname(int t);
      case (t)
         1: return "R1";
         7: return "R7";
         8: return "R8";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // expected outputs from the frame tick, per the requirement arithmetic
   task automatic check_item(item_t it);
      int n, len, ph, s, pol, com, bnk, syn;
      bit rst;
      n   = it.m + 1;
      len = 24 / n;
      ph  = it.k / len;
      s   = it.k % len;
      pol = (s >= len / 2) ? 1 : 0;
      com = 0;
      for (int i = 0; i < 4; i++) begin
         com |= (((i == ph) ? 2 : 0) | pol) << (2 * i);
      end
      bnk = 1 << ph;
      syn = (it.mst && it.k == 0) ? 1 : 0;
      rst = (it.tag == 1);
      chk(tagname(it.tag), "phase_idx", int'(phase_idx), ph);
      chk(rst ? "R1" : "R3", "polarity", int'(polarity), pol);
      chk(rst ? "R1" : "R4", "com_level", int'(com_level), com);
      chk(rst ? "R1" : "R5", "bank_sel", int'(bank_sel), bnk);
      chk(rst ? "R1" : (it.mst ? "R6" : "R7"), "sync_out", int'(sync_out), syn);
   endtask

   // driver: apply inputs at a falling edge, queue the tick due after the next rise
   task automatic step(int m, bit mst, bit s);
      item_t it;
      int t;
      if (m != cur_m) begin
         cur_k = 0; t = 8;              // R8 restart
      end else if (!mst && s && !prev_sync) begin
         cur_k = 1; t = 7;              // R7 align
      end else begin
         cur_k = (cur_k + 1) % 24; t = 2;
      end
      cur_m     = m;
      prev_sync = s;
      duty_sel  = 2'(m);
      is_master = mst;
      sync_in   = s;
      it.k = cur_k; it.m = m; it.mst = mst; it.tag = t;
      q.push_back(it);
      @(negedge clk);
   endtask

   task automatic run(int m, bit mst, int cycles);
      for (int i = 0; i < cycles; i++) step(m, mst, 1'b0);
   endtask

   // monitor
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) check_item(q.pop_front());
   end

   initial begin
      item_t r;
      rst_n = 1'b0; duty_sel = 2'd0; is_master = 1'b1; sync_in = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      r.k = 0; r.m = 0; r.mst = 1; r.tag = 1;
      check_item(r);
      rst_n = 1'b1;
      run(0, 1, 30);                     // static, master, frame wrap (R2 R6)
      step(0, 1, 1); step(0, 1, 1);      // R6 master ignores sync_in
      step(0, 1, 0);
      run(1, 1, 30);                     // 1/2 duty
      run(2, 1, 30);                     // 1/3 duty
      run(3, 1, 30);                     // 1/4 duty
      run(3, 0, 5);                      // slave free runs, no sync_out (R7)
      step(3, 0, 1);                     // R7 align
      step(3, 0, 1); step(3, 0, 1);      // held high: no further restart
      run(3, 0, 10);
      step(3, 0, 1);
      run(3, 0, 30);
      step(1, 0, 1);                     // R8 restart wins over sync edge
      run(1, 0, 30);
      run(0, 1, 30);                     // back to static master (R8)
      run(2, 0, 20);
      step(2, 0, 1);
      run(2, 0, 20);
      @(negedge clk); @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL R2 watchdog expired actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule